// File: doc/BRIEF.md
# Four-Way Branch Sequencer

This block is the control unit of a small stored-program machine, built around a 16-word control store. A 4-bit state register addresses the store. Each word holds the control-point vector for its state, four candidate successor states, and two select bits. The select bits decide which two status conditions the sequencer looks at in that state. Those two conditions form a 2-bit way index, and the index picks one of the four stored successors. That successor is loaded as the next state. No next-state logic is synthesised beyond two 2:1 condition multiplexers and one 4:1 successor multiplexer. Changing the machine's behaviour only means changing the store contents, which are a parameter.

The status conditions are:

- a memory handshake flag;
- the two top opcode bits of the instruction register;
- the sign bit of the accumulator.

The control vector is a Moore output. It depends only on the current state and stays steady for the whole cycle. The datapath it drives is outside this block. The default contents implement the following sequence:

- a reset state;
- a four-state fetch with wait loops;
- a four-way decode;
- short load, store, add and conditional-branch routines.

Top module: `bseq_ctrl`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `state_out` becomes 0 after that edge, whatever the store word and the condition inputs.
- R2: `ctrl_out` always equals bits [21:0] of the store word addressed by `state_out`.
- R3: Word `i` of the store is `STORE[i*40 +: 40]`. Within a word:
  - bit 39 is the alpha select;
  - bit 38 is the beta select;
  - bits [37:34] hold successor A3;
  - bits [33:30] hold successor A2;
  - bits [29:26] hold successor A1;
  - bits [25:22] hold successor A0.
- R4: The alpha condition is `mem_wait` when the alpha select is 0, and `ir_op_hi` when it is 1. The beta condition is `acc_sign` when the beta select is 0, and `ir_op_lo` when it is 1.
- R5: Out of reset, the next state is successor A{alpha,beta}: A0 for 00, A1 for 01, A2 for 10 and A3 for 11, with alpha as the high bit.
- R6: With the default store, state 0 moves to state 1 for every condition pattern.
- R7: With the default store, state 5 (decode) selects both opcode bits. {ir_op_hi, ir_op_lo} = 00, 01, 10 and 11 lead to states 6, 9, 11 and 14 respectively.
- R8: With the default store, state 2 stays in state 2 while `mem_wait` is 0 and moves to state 3 when `mem_wait` is 1.
- R9: `ctrl_out` changes only when `state_out` changes, so the condition inputs never reach it within a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_wait | input | 1 | Memory handshake flag (1 = transfer done) |
| ir_op_hi | input | 1 | Instruction register bit 15 |
| ir_op_lo | input | 1 | Instruction register bit 14 |
| acc_sign | input | 1 | Accumulator sign bit |
| ctrl_out | output | 22 | Control-point vector of the current state |
| state_out | output | 4 | Current state |

## Verification
The bench builds two copies of the block, both with STATE_W = 4 and CTRL_W = 22.

The first copy uses the default store. Directed walks through the fetch wait loop and all four decode outcomes check the shipped microcode.

The second copy gets a pseudo-randomly generated store passed through the STORE parameter. In that store, words with every alpha/beta select combination and arbitrary successors occur. Random condition inputs therefore exercise all four ways under both condition sources, which the default store alone never reaches. The second copy also carries arbitrary control vectors, so the word layout and the Moore read path are checked across all 16 words.

// File: rtl/bseq_pkg.sv
// Package: bseq_pkg
// Shared widths and the default microcode of the four-way branch sequencer.
// Assumes the word layout {alpha_sel, beta_sel, A3, A2, A1, A0, ctrl}.
package bseq_pkg;

    localparam int DEF_STATE_W = 4;
    localparam int DEF_CTRL_W  = 22;
    localparam int DEF_DEPTH   = 1 << DEF_STATE_W;
    localparam int DEF_WORD_W  = 2 + 4 * DEF_STATE_W + DEF_CTRL_W;

    // Pack one control-store word from its fields.
    function automatic logic [DEF_WORD_W-1:0] mk_word(
        input logic                   a_sel,
        input logic                   b_sel,
        input logic [DEF_STATE_W-1:0] s3,
        input logic [DEF_STATE_W-1:0] s2,
        input logic [DEF_STATE_W-1:0] s1,
        input logic [DEF_STATE_W-1:0] s0,
        input logic [DEF_CTRL_W-1:0]  ctl
    );
        return {a_sel, b_sel, s3, s2, s1, s0, ctl};
    endfunction

    // Default microcode: reset, fetch, decode, load, store, add, branch.
    function automatic logic [DEF_DEPTH*DEF_WORD_W-1:0] default_store();
        logic [DEF_DEPTH*DEF_WORD_W-1:0] t;
        t = '0;
        t[ 0*DEF_WORD_W +: DEF_WORD_W] = mk_word(1'b0, 1'b0, 4'd1,  4'd1,  4'd1,  4'd1,  22'h000003);
        t[ 1*DEF_WORD_W +: DEF_WORD_W] = mk_word(1'b0, 1'b0, 4'd2,  4'd2,  4'd2,  4'd2,  22'h000104);
        t[ 2*DEF_WORD_W +: DEF_WORD_W] = mk_word(1'b0, 1'b0, 4'd3,  4'd3,  4'd2,  4'd2,  22'h000108);
        t[ 3*DEF_WORD_W +: DEF_WORD_W] = mk_word(1'b0, 1'b0, 4'd3,  4'd3,  4'd4,  4'd4,  22'h000210);
        t[ 4*DEF_WORD_W +: DEF_WORD_W] = mk_word(1'b0, 1'b0, 4'd5,  4'd5,  4'd4,  4'd4,  22'h000420);
        t[ 5*DEF_WORD_W +: DEF_WORD_W] = mk_word(1'b1, 1'b1, 4'd14, 4'd11, 4'd9,  4'd6,  22'h000000);
        t[ 6*DEF_WORD_W +: DEF_WORD_W] = mk_word(1'b0, 1'b0, 4'd7,  4'd7,  4'd7,  4'd7,  22'h000840);
        t[ 7*DEF_WORD_W +: DEF_WORD_W] = mk_word(1'b0, 1'b0, 4'd7,  4'd7,  4'd8,  4'd8,  22'h001108);
        t[ 8*DEF_WORD_W +: DEF_WORD_W] = mk_word(1'b0, 1'b0, 4'd1,  4'd1,  4'd1,  4'd1,  22'h002080);
        t[ 9*DEF_WORD_W +: DEF_WORD_W] = mk_word(1'b0, 1'b0, 4'd10, 4'd10, 4'd10, 4'd10, 22'h004840);
        t[10*DEF_WORD_W +: DEF_WORD_W] = mk_word(1'b0, 1'b0, 4'd10, 4'd10, 4'd1,  4'd1,  22'h008300);
        t[11*DEF_WORD_W +: DEF_WORD_W] = mk_word(1'b0, 1'b0, 4'd12, 4'd12, 4'd12, 4'd12, 22'h000840);
        t[12*DEF_WORD_W +: DEF_WORD_W] = mk_word(1'b0, 1'b0, 4'd12, 4'd12, 4'd13, 4'd13, 22'h001108);
        t[13*DEF_WORD_W +: DEF_WORD_W] = mk_word(1'b0, 1'b0, 4'd1,  4'd1,  4'd1,  4'd1,  22'h070000);
        t[14*DEF_WORD_W +: DEF_WORD_W] = mk_word(1'b0, 1'b0, 4'd15, 4'd1,  4'd15, 4'd1,  22'h000000);
        t[15*DEF_WORD_W +: DEF_WORD_W] = mk_word(1'b0, 1'b0, 4'd1,  4'd1,  4'd1,  4'd1,  22'h280000);
        return t;
    endfunction

endpackage

// File: rtl/bseq_store.sv
// Module: bseq_store
// Combinational control-store read. Splits the flat STORE parameter into
// words and returns the fields of the word at addr.
// Assumes STORE is DEPTH words of WORD_W bits, word i at [i*WORD_W +: WORD_W].
module bseq_store #(
    parameter int STATE_W = 4,
    parameter int CTRL_W  = 22,
    parameter int DEPTH   = 1 << STATE_W,
    parameter int WORD_W  = 2 + 4 * STATE_W + CTRL_W,
    parameter logic [DEPTH*WORD_W-1:0] STORE = '0
) (
    input  logic [STATE_W-1:0]   addr,
    output logic                 alpha_sel,
    output logic                 beta_sel,
    output logic [4*STATE_W-1:0] succ_all,
    output logic [CTRL_W-1:0]    ctrl
);

    localparam int SUCC_LSB = CTRL_W;
    localparam int BETA_BIT = CTRL_W + 4 * STATE_W;
    localparam int ALFA_BIT = BETA_BIT + 1;

    logic [WORD_W-1:0] words [DEPTH];
    logic [WORD_W-1:0] cur;

    generate
        for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
            assign words[gi] = STORE[gi*WORD_W +: WORD_W];
        end
    endgenerate

    // Select the addressed word and split it into fields.
    always_comb begin
        cur       = words[addr];
        alpha_sel = cur[ALFA_BIT];
        beta_sel  = cur[BETA_BIT];
        succ_all  = cur[SUCC_LSB +: 4*STATE_W];
        ctrl      = cur[CTRL_W-1:0];
    end

endmodule

// File: rtl/bseq_cond_sel.sv
// Module: bseq_cond_sel
// Picks the alpha and beta conditions and forms the 2-bit way index.
// Assumes alpha is the high bit of the index.
module bseq_cond_sel (
    input  logic       alpha_sel,
    input  logic       beta_sel,
    input  logic       mem_wait,
    input  logic       ir_op_hi,
    input  logic       ir_op_lo,
    input  logic       acc_sign,
    output logic [1:0] way
);

    logic alpha_c;
    logic beta_c;

    // Two 2:1 condition multiplexers feeding the way index.
    always_comb begin
        alpha_c = alpha_sel ? ir_op_hi : mem_wait;
        beta_c  = beta_sel  ? ir_op_lo : acc_sign;
        way     = {alpha_c, beta_c};
    end

endmodule

// File: rtl/bseq_succ_pick.sv
// Module: bseq_succ_pick
// Chooses one of the four stored successors by way index.
// Assumes succ_all holds A0 in its low STATE_W bits and A3 in its top bits.
module bseq_succ_pick #(
    parameter int STATE_W = 4,
    parameter int WAYS    = 4
) (
    input  logic [WAYS*STATE_W-1:0] succ_all,
    input  logic [1:0]              way,
    output logic [STATE_W-1:0]      next_state
);

    logic [STATE_W-1:0] cand [WAYS];

    generate
        for (genvar gw = 0; gw < WAYS; gw++) begin : g_cand
            assign cand[gw] = succ_all[gw*STATE_W +: STATE_W];
        end
    endgenerate

    // 4:1 successor multiplexer.
    always_comb begin
        next_state = cand[way];
    end

endmodule

// File: rtl/bseq_ctrl.sv
// Module: bseq_ctrl (top)
// Four-way branch sequencer: a state register addressing a control store
// whose words name four successors; two selected conditions pick one.
// Assumes synchronous active-low reset; ctrl_out is a Moore output.
module bseq_ctrl #(
    parameter int STATE_W = bseq_pkg::DEF_STATE_W,
    parameter int CTRL_W  = bseq_pkg::DEF_CTRL_W,
    parameter logic [(1<<STATE_W)*(2+4*STATE_W+CTRL_W)-1:0] STORE =
        bseq_pkg::default_store()
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mem_wait,
    input  logic               ir_op_hi,
    input  logic               ir_op_lo,
    input  logic               acc_sign,
    output logic [CTRL_W-1:0]  ctrl_out,
    output logic [STATE_W-1:0] state_out
);

    localparam int DEPTH  = 1 << STATE_W;
    localparam int WORD_W = 2 + 4 * STATE_W + CTRL_W;

    logic [STATE_W-1:0]   state_q;
    logic [STATE_W-1:0]   state_d;
    logic                 a_sel;
    logic                 b_sel;
    logic [4*STATE_W-1:0] succ_all;
    logic [1:0]           way;

    bseq_store #(
        .STATE_W (STATE_W),
        .CTRL_W  (CTRL_W),
        .DEPTH   (DEPTH),
        .WORD_W  (WORD_W),
        .STORE   (STORE)
    ) u_store (
        .addr      (state_q),
        .alpha_sel (a_sel),
        .beta_sel  (b_sel),
        .succ_all  (succ_all),
        .ctrl      (ctrl_out)
    );

    bseq_cond_sel u_cond (
        .alpha_sel (a_sel),
        .beta_sel  (b_sel),
        .mem_wait  (mem_wait),
        .ir_op_hi  (ir_op_hi),
        .ir_op_lo  (ir_op_lo),
        .acc_sign  (acc_sign),
        .way       (way)
    );

    bseq_succ_pick #(
        .STATE_W (STATE_W),
        .WAYS    (4)
    ) u_pick (
        .succ_all   (succ_all),
        .way        (way),
        .next_state (state_d)
    );

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign state_out = state_q;

endmodule

// File: rtl/bseq_ctrl_chk.sv
// Module: bseq_ctrl_chk
// Assertion checker for bseq_ctrl, decoding the store from the word layout
// at the ports only. Bound to every bseq_ctrl instance below.
module bseq_ctrl_chk #(
    parameter int STATE_W = 4,
    parameter int CTRL_W  = 22,
    parameter logic [(1<<STATE_W)*(2+4*STATE_W+CTRL_W)-1:0] STORE = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_wait,
    input logic               ir_op_hi,
    input logic               ir_op_lo,
    input logic               acc_sign,
    input logic [CTRL_W-1:0]  ctrl_out,
    input logic [STATE_W-1:0] state_out
);

    localparam int DEPTH  = 1 << STATE_W;
    localparam int WORD_W = 2 + 4 * STATE_W + CTRL_W;

    logic [WORD_W-1:0]  cw [DEPTH];
    logic [WORD_W-1:0]  w;
    logic               ac;
    logic               bc;
    logic [1:0]         ix;
    logic [STATE_W-1:0] exp_next;

    generate
        for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cw
            assign cw[gi] = STORE[gi*WORD_W +: WORD_W];
        end
    endgenerate

    // Reference successor of the current state under the present inputs.
    always_comb begin
        w        = cw[state_out];
        ac       = w[WORD_W-1] ? ir_op_hi : mem_wait;
        bc       = w[WORD_W-2] ? ir_op_lo : acc_sign;
        ix       = {ac, bc};
        exp_next = w[CTRL_W + ix*STATE_W +: STATE_W];
    end

    a_r1_sync_reset: assert property (@(posedge clk)
        !rst_n |=> state_out == '0);

    a_r2_moore_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_out == w[CTRL_W-1:0]);

    a_r5_successor: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> state_out == $past(exp_next));

    a_r9_ctrl_steady: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(state_out) |-> $stable(ctrl_out));

endmodule

bind bseq_ctrl bseq_ctrl_chk #(
    .STATE_W (STATE_W),
    .CTRL_W  (CTRL_W),
    .STORE   (STORE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_wait  (mem_wait),
    .ir_op_hi  (ir_op_hi),
    .ir_op_lo  (ir_op_lo),
    .acc_sign  (acc_sign),
    .ctrl_out  (ctrl_out),
    .state_out (state_out)
);

// File: tb/tb_bseq_ctrl.sv
// Bench for bseq_ctrl: a scrambled-store copy (dut) and a default-store copy
// (dut_def), both checked against bench models built from the requirements.
module tb_bseq_ctrl;

    localparam int SW = 4;
    localparam int CW = 22;
    localparam int WW = 40;
    localparam int TW = 16 * WW;

    // Pseudo-random store built from a fixed-seed LCG (R3 layout).
    function automatic logic [TW-1:0] scramble();
        logic [TW-1:0] t;
        logic [31:0]   x;
        logic [31:0]   lo;
        t = '0;
        x = 32'h1F2E_3D4C;
        for (int i = 0; i < 16; i++) begin
            x  = x * 32'd1664525 + 32'd1013904223;
            lo = x;
            x  = x * 32'd1664525 + 32'd1013904223;
            t[i*WW +: WW] = {x[15:8], lo};
        end
        return t;
    endfunction

    // Bench copy of the default sequencing (selects and successors only).
    function automatic logic [WW-1:0] dw(input logic a, input logic b,
        input int s3, input int s2, input int s1, input int s0);
        return {a, b, s3[3:0], s2[3:0], s1[3:0], s0[3:0], 22'h0};
    endfunction

    function automatic logic [TW-1:0] def_tab();
        logic [TW-1:0] t;
        t = '0;
        t[ 0*WW +: WW] = dw(0, 0,  1,  1,  1,  1);
        t[ 1*WW +: WW] = dw(0, 0,  2,  2,  2,  2);
        t[ 2*WW +: WW] = dw(0, 0,  3,  3,  2,  2);
        t[ 3*WW +: WW] = dw(0, 0,  3,  3,  4,  4);
        t[ 4*WW +: WW] = dw(0, 0,  5,  5,  4,  4);
        t[ 5*WW +: WW] = dw(1, 1, 14, 11,  9,  6);
        t[ 6*WW +: WW] = dw(0, 0,  7,  7,  7,  7);
        t[ 7*WW +: WW] = dw(0, 0,  7,  7,  8,  8);
        t[ 8*WW +: WW] = dw(0, 0,  1,  1,  1,  1);
        t[ 9*WW +: WW] = dw(0, 0, 10, 10, 10, 10);
        t[10*WW +: WW] = dw(0, 0, 10, 10,  1,  1);
        t[11*WW +: WW] = dw(0, 0, 12, 12, 12, 12);
        t[12*WW +: WW] = dw(0, 0, 12, 12, 13, 13);
        t[13*WW +: WW] = dw(0, 0,  1,  1,  1,  1);
        t[14*WW +: WW] = dw(0, 0, 15,  1, 15,  1);
        t[15*WW +: WW] = dw(0, 0,  1,  1,  1,  1);
        return t;
    endfunction

    localparam logic [TW-1:0] SCR = scramble();
    localparam logic [TW-1:0] DEF = def_tab();

    // Next state per R4/R5 from the R3 layout.
    function automatic logic [SW-1:0] model_next(input logic [TW-1:0] t,
        input logic [SW-1:0] s, input logic w, input logic h,
        input logic l, input logic a);
        logic [WW-1:0] wd;
        logic [1:0]    ix;
        wd = t[s*WW +: WW];
        ix = {wd[39] ? h : w, wd[38] ? l : a};
        return wd[22 + ix*4 +: 4];
    endfunction

    function automatic logic [CW-1:0] model_ctrl(input logic [TW-1:0] t,
        input logic [SW-1:0] s);
        logic [WW-1:0] wd;
        wd = t[s*WW +: WW];
        return wd[21:0];
    endfunction

    logic clk = 1'b0;
    logic rst_n, mem_wait, ir_op_hi, ir_op_lo, acc_sign;
    logic [CW-1:0] ctrl_s, ctrl_d;
    logic [SW-1:0] st_s, st_d;
    logic [SW-1:0] ms, md;
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    bseq_ctrl #(.STATE_W(SW), .CTRL_W(CW), .STORE(SCR)) dut (
        .clk(clk), .rst_n(rst_n), .mem_wait(mem_wait), .ir_op_hi(ir_op_hi),
        .ir_op_lo(ir_op_lo), .acc_sign(acc_sign),
        .ctrl_out(ctrl_s), .state_out(st_s));

    bseq_ctrl #(.STATE_W(SW), .CTRL_W(CW)) dut_def (
        .clk(clk), .rst_n(rst_n), .mem_wait(mem_wait), .ir_op_hi(ir_op_hi),
        .ir_op_lo(ir_op_lo), .acc_sign(acc_sign),
        .ctrl_out(ctrl_d), .state_out(st_d));

    task automatic check(input string req, input logic [31:0] act,
        input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, update models, compare at next negedge.
    task automatic cyc(input logic r, input logic w, input logic h,
        input logic l, input logic a);
        rst_n = r; mem_wait = w; ir_op_hi = h; ir_op_lo = l; acc_sign = a;
        @(posedge clk);
        ms = r ? model_next(SCR, ms, w, h, l, a) : '0;
        md = r ? model_next(DEF, md, w, h, l, a) : '0;
        @(negedge clk);
        if (!r) begin
            check("R1 reset scr", 32'(st_s), 32'(0));
            check("R1 reset def", 32'(st_d), 32'(0));
        end else begin
            check("R5 next scr", 32'(st_s), 32'(ms));
            check("R5 next def", 32'(st_d), 32'(md));
        end
        check("R2 ctrl", 32'(ctrl_s), 32'(model_ctrl(SCR, ms)));
    endtask

    // Walk the default store from reset into decode (state 5).
    task automatic to_decode();
        cyc(0, 0, 0, 0, 0);
        cyc(1, 1, 1, 1, 1);
        check("R6 reset to fetch", 32'(st_d), 32'(1));
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 1, 1, 1);
        check("R8 wait hold", 32'(st_d), 32'(2));
        cyc(1, 1, 0, 0, 0);
        check("R8 wait release", 32'(st_d), 32'(3));
        cyc(1, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0);
        check("R7 reach decode", 32'(st_d), 32'(5));
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        if (!done) begin
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        logic [CW-1:0] c0;
        rst_n = 0; mem_wait = 0; ir_op_hi = 0; ir_op_lo = 0; acc_sign = 0;
        ms = '0; md = '0;
        repeat (2) @(negedge clk);
        check("R1 reset state", 32'(st_s), 32'(0));
        check("R1 reset state def", 32'(st_d), 32'(0));
        check("R2 ctrl at reset", 32'(ctrl_s), 32'(model_ctrl(SCR, 4'd0)));

        // R7 all four decode outcomes: 00->6, 01->9, 10->11, 11->14
        for (int k = 0; k < 4; k++) begin
            to_decode();
            cyc(1, 0, k[1], k[0], 0);
            check("R7 decode target", 32'(st_d),
                  (k == 0) ? 32'd6 : (k == 1) ? 32'd9 : (k == 2) ? 32'd11 : 32'd14);
        end

        // R9: condition changes within a cycle leave ctrl_out untouched.
        cyc(0, 0, 0, 0, 0);
        c0 = ctrl_s;
        mem_wait = 1; ir_op_hi = 1; ir_op_lo = 1; acc_sign = 1;
        #1;
        check("R9 ctrl ignores inputs", 32'(ctrl_s), 32'(c0));

        // Random run; R4/R5 on both stores, R1 on sporadic resets.
        for (int i = 0; i < 4000; i++) begin
            rv = $urandom();
            cyc((rv[9:4] != 0), rv[0], rv[1], rv[2], rv[3]);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd77));
    end

endmodule